// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

A memory-mapped watchdog that counts down in coarse ticks and forces a system reset when software stops servicing it. A prescaler divides the core clock into ticks (1/64 s on silicon, a few cycles in simulation). A 10-bit down-counter loads from the programmed length. Software keeps the system alive by writing a restart word, which reloads the counter.

Every write that changes behaviour must carry a magic value:
- A control write needs a key byte in its top bits.
- A length write needs a key in its low five bits.
- The restart and software-reset registers act only on one exact 32-bit word each.

A write with the wrong value changes nothing.

On expiry the block can do three things:
- pulse a reset output of selectable polarity;
- raise an interrupt;
- in two-stage mode, raise the interrupt first and reset only if a second expiry arrives while the interrupt is still pending.

A sticky status word records whether the last reset cause was a timeout or a software request. Reads are combinational from the address bus.

Top module: `wdt_top`

## Requirements
- R1: A write to offset 0x00 is accepted only when wdata[31:24] = 0x22; it then sets run enable (bit 0), reset polarity (bit 1), reset-output enable (bit 2), interrupt enable (bit 3) and two-stage mode (bit 6). A read of 0x00 returns these bits in the same positions and zero elsewhere. All fields reset to 0.
- R2: A write to offset 0x04 is accepted only when wdata[4:0] = 0x08; it stores the tick count from wdata[14:5]. A read returns the count in bits [14:5] and zero elsewhere. The count resets to 1023.
- R3: Writing exactly 0x0000_1971 to offset 0x08 reloads the counter from the length and restarts the prescaler. Any other value leaves the counter unchanged. Offset 0x10 reads the current count in bits [9:0].
- R4: While enabled, an expiry occurs exactly length × TICK_DIV cycles after the restart write's clock edge.
- R5: The reset output is high-active when the polarity bit is 1 and low-active when it is 0; otherwise it rests at the inactive level.
- R6: A reset pulse lasts exactly PULSE_CYC cycles.
- R7: Writing exactly 0x0000_1209 to offset 0x14 starts a reset pulse on the next cycle whether or not the counter is enabled. Other values do nothing.
- R8: Status at offset 0x0C has bit 31 for software-reset cause and bit 30 for timeout cause. The bits are sticky, are cleared only by rst_ni, and all other bits read 0.
- R9: With run enable clear, the counter and prescaler hold their values.
- R10: On expiry with interrupt enable set and two-stage mode clear, irq_o rises and no reset pulse is issued. A restart write clears irq_o.
- R11: With both interrupt enable and two-stage mode set, an expiry while irq_o is already high pulses the reset (if the reset output is enabled). With interrupt enable clear, every expiry pulses the reset when the reset output is enabled.
- R12: A restart write on the same clock edge as a pending expiry wins: the counter reloads and no expiry takes effect.
- R13: A programmed length of 0 behaves as one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 5 | Byte offset of register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| wdt_rst_o | output | 1 | Reset output, polarity per control |
| irq_o | output | 1 | Expiry interrupt |

## Verification
A restart write and a counter expiry can land on the same clock edge. That is the race a real system loses when service arrives at the last moment.

The bench times a restart write so that it is latched on exactly the edge where the counter would step from 1 to expiry. It then requires that the reset output stays inactive and that the interval register reads the full reloaded length. It also confirms the following cases at cycle-exact boundaries:
- expiry with no restart pending;
- two-stage escalation;
- a software reset issued while disabled.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [4:0]  OFS_MODE    = 5'h00;
  localparam logic [4:0]  OFS_LEN     = 5'h04;
  localparam logic [4:0]  OFS_RESTART = 5'h08;
  localparam logic [4:0]  OFS_STAT    = 5'h0C;
  localparam logic [4:0]  OFS_CNT     = 5'h10;
  localparam logic [4:0]  OFS_SWRST   = 5'h14;

  localparam logic [7:0]  MODE_KEY    = 8'h22;
  localparam logic [4:0]  LEN_KEY     = 5'h08;
  localparam logic [31:0] RESTART_KEY = 32'h0000_1971;
  localparam logic [31:0] SWRST_KEY   = 32'h0000_1209;
  localparam int unsigned LEN_LSB     = 5;

  typedef struct packed {
    logic dual;
    logic irq_en;
    logic ext_en;
    logic pol;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned LEN_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [4:0]       addr_i,
  input  logic [31:0]      wdata_i,
  input  logic [LEN_W-1:0] cnt_i,
  input  logic             expire_i,
  output ctrl_t            ctrl_o,
  output logic [LEN_W-1:0] len_o,
  output logic             restart_o,
  output logic             swrst_o,
  output logic             stat_to_o,
  output logic             stat_sw_o,
  output logic [31:0]      rdata_o
);
  logic wr_mode, wr_len;

  assign wr_mode   = wr_en_i && addr_i == OFS_MODE && wdata_i[31:24] == MODE_KEY;
  assign wr_len    = wr_en_i && addr_i == OFS_LEN && wdata_i[4:0] == LEN_KEY;
  assign restart_o = wr_en_i && addr_i == OFS_RESTART && wdata_i == RESTART_KEY;
  assign swrst_o   = wr_en_i && addr_i == OFS_SWRST && wdata_i == SWRST_KEY;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o    <= '0;
      len_o     <= '1;
      stat_to_o <= 1'b0;
      stat_sw_o <= 1'b0;
    end else begin
      if (wr_mode) ctrl_o <= '{dual: wdata_i[6], irq_en: wdata_i[3], ext_en: wdata_i[2],
                               pol: wdata_i[1], en: wdata_i[0]};
      if (wr_len) len_o <= wdata_i[LEN_LSB +: LEN_W];
      if (expire_i) stat_to_o <= 1'b1;
      if (swrst_o) stat_sw_o <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_MODE: rdata_o[6:0] = {ctrl_o.dual, 2'b00, ctrl_o.irq_en, ctrl_o.ext_en,
                                ctrl_o.pol, ctrl_o.en};
      OFS_LEN:  rdata_o[LEN_LSB +: LEN_W] = len_o;
      OFS_STAT: rdata_o[31:30] = {stat_sw_o, stat_to_o};
      OFS_CNT:  rdata_o[LEN_W-1:0] = cnt_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_tick.sv
module wdt_tick #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  if (DIV <= 1) begin : g_direct
    assign tick_o = run_i;
  end else begin : g_div
    localparam int unsigned W = $clog2(DIV);
    localparam logic [W-1:0] LAST = W'(DIV - 1);
    logic [W-1:0] pre_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pre_q <= '0;
      else if (clr_i)  pre_q <= '0;
      else if (run_i)  pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
    end

    assign tick_o = run_i && pre_q == LAST;
  end
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int unsigned LEN_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [LEN_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [LEN_W-1:0] len_eff;

  // zero length clamps to one tick
  assign len_eff  = (len_i == '0) ? LEN_W'(1) : len_i;
  assign expire_o = run_i && tick_i && !reload_i && cnt_o <= LEN_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_o <= '1;
    else if (reload_i || expire_o) cnt_o <= len_eff;
    else if (run_i && tick_i)     cnt_o <= cnt_o - 1'b1;
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int unsigned CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic active_o
);
  localparam int unsigned W = $clog2(CYC + 1);
  logic [W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             left_q <= '0;
    else if (fire_i)         left_q <= W'(CYC);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign active_o = left_q != '0;
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int unsigned TICK_DIV  = 1953125,
  parameter int unsigned PULSE_CYC = 64,
  parameter int unsigned LEN_W     = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [4:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        wdt_rst_o,
  output logic        irq_o
);
  ctrl_t            ctrl_q;
  logic [LEN_W-1:0] len_q, cnt_q;
  logic             restart, swrst, tick, expire;
  logic             stat_to, stat_sw;
  logic             irq_q, rst_fire, rst_act;

  wdt_regs #(.LEN_W(LEN_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .cnt_i(cnt_q), .expire_i(expire),
    .ctrl_o(ctrl_q), .len_o(len_q), .restart_o(restart), .swrst_o(swrst),
    .stat_to_o(stat_to), .stat_sw_o(stat_sw), .rdata_o
  );

  wdt_tick #(.DIV(TICK_DIV)) u_tick (
    .clk_i, .rst_ni, .run_i(ctrl_q.en), .clr_i(restart), .tick_o(tick)
  );

  wdt_count #(.LEN_W(LEN_W)) u_count (
    .clk_i, .rst_ni, .run_i(ctrl_q.en), .tick_i(tick), .reload_i(restart),
    .len_i(len_q), .cnt_o(cnt_q), .expire_o(expire)
  );

  // two-stage: escalate only when the earlier interrupt is still pending
  assign rst_fire = swrst ||
                    (expire && ctrl_q.ext_en &&
                     (!ctrl_q.irq_en || (ctrl_q.dual && irq_q)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         irq_q <= 1'b0;
    else if (restart)                    irq_q <= 1'b0;
    else if (expire && ctrl_q.irq_en)    irq_q <= 1'b1;
  end

  wdt_pulse #(.CYC(PULSE_CYC)) u_pulse (
    .clk_i, .rst_ni, .fire_i(rst_fire), .active_o(rst_act)
  );

  assign wdt_rst_o = ctrl_q.pol ? rst_act : ~rst_act;
  assign irq_o     = irq_q;
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
  import wdt_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 64,
  parameter int unsigned LEN_W     = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [4:0]       addr_i,
  input logic [31:0]      wdata_i,
  input logic             rst_act,
  input logic             rst_fire,
  input logic             irq_o,
  input logic             expire,
  input logic             en,
  input logic             stat_to,
  input logic             stat_sw,
  input logic [LEN_W-1:0] cnt,
  input logic [LEN_W-1:0] len
);
  localparam int unsigned RW = $clog2(PULSE_CYC + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_q <= '0;
    else if (rst_fire) run_q <= RW'(1);
    else if (rst_act)  run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  // R6
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_act |-> run_q <= RW'(PULSE_CYC));

  // R7
  swrst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_SWRST && wdata_i == SWRST_KEY) |=> (rst_act && stat_sw));

  // R1
  mode_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_MODE && wdata_i[31:24] != MODE_KEY) |=> $stable(en));

  // R3
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_RESTART && wdata_i == RESTART_KEY) |=>
      cnt == (($past(len) == '0) ? LEN_W'(1) : $past(len)));

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !(wr_en_i && addr_i == OFS_RESTART && wdata_i == RESTART_KEY)) |=> $stable(cnt));

  // R10
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(expire));

  // R8
  stat_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(stat_to) && !$fell(stat_sw));
endmodule

bind wdt_top wdt_chk #(.PULSE_CYC(PULSE_CYC), .LEN_W(LEN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rst_act(rst_act), .rst_fire(rst_fire), .irq_o(irq_o),
  .expire(expire), .en(ctrl_q.en), .stat_to(stat_to), .stat_sw(stat_sw),
  .cnt(cnt_q), .len(len_q)
);

// File: tb/sim_wdt_top.sv
module sim_wdt_top;
  localparam int unsigned DIV = 4;
  localparam int unsigned PW  = 5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        wdt_rst_o, irq_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] mode_m, len_m, v, v2;

  wdt_top #(.TICK_DIV(DIV), .PULSE_CYC(PW), .LEN_W(10)) u0 (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o, .wdt_rst_o, .irq_o
  );

  always #4 clk_i = ~clk_i;

  function automatic logic [31:0] exp_mode(input logic [31:0] d);
    return {25'b0, d[6], 2'b00, d[3:0]};
  endfunction

  function automatic logic [31:0] exp_len(input logic [31:0] d);
    return {17'b0, d[14:5], 5'b0};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; write latched on next posedge, returns at following negedge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic pulse_width(input logic act, input string tag);
    chk(wdt_rst_o == act, tag, 32'(wdt_rst_o), 32'(act));
    for (int k = 1; k < PW; k++) begin
      @(negedge clk_i);
      chk(wdt_rst_o == act, tag, 32'(wdt_rst_o), 32'(act));
    end
    @(negedge clk_i);
    chk(wdt_rst_o == !act, tag, 32'(wdt_rst_o), 32'(!act));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog timeout actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // reset state: R1 R2 R8 R5
    rd(5'h00, v); chk(v == 0, "R1 mode reset", v, 0);
    rd(5'h04, v); chk(v == 32'h7FE0, "R2 length reset", v, 32'h7FE0);
    rd(5'h0C, v); chk(v == 0, "R8 status reset", v, 0);
    rd(5'h10, v); chk(v == 1023, "R3 count reset", v, 1023);
    chk(wdt_rst_o == 1'b1 && irq_o == 1'b0, "R5 idle outputs", {wdt_rst_o, irq_o}, 2'b10);

    // R1 random mode writes, half with correct key
    mode_m = 0;
    for (int i = 0; i < 16; i++) begin
      v = $urandom;
      if (i % 2 == 1) v[31:24] = 8'h22;
      else if (v[31:24] == 8'h22) v[31:24] = 8'h23;
      @(negedge clk_i); wr(5'h00, v);
      if (v[31:24] == 8'h22) mode_m = exp_mode(v);
      rd(5'h00, v2); chk(v2 == mode_m, "R1 mode key", v2, mode_m);
    end
    wr(5'h00, 32'h2200_0000);

    // R2 random length writes
    len_m = 32'h7FE0;
    for (int i = 0; i < 16; i++) begin
      v = $urandom;
      if (i % 2 == 1) v[4:0] = 5'h08;
      else if (v[4:0] == 5'h08) v[4:0] = 5'h09;
      wr(5'h04, v);
      if (v[4:0] == 5'h08) len_m = exp_len(v);
      rd(5'h04, v2); chk(v2 == len_m, "R2 length key", v2, len_m);
    end

    // R3 random non-key restart values leave the held count unchanged
    wr(5'h04, (32'd7 << 5) | 32'h8);
    rd(5'h10, v);
    for (int i = 0; i < 8; i++) begin
      v2 = $urandom;
      if (v2 == 32'h1971) v2 = 32'h1972;
      wr(5'h08, v2);
      rd(5'h10, v2); chk(v2 == v, "R3 bad restart ignored", v2, v);
    end
    wr(5'h08, 32'h1971);
    rd(5'h10, v); chk(v == 7, "R3 restart reloads", v, 7);

    // R9 hold while disabled
    repeat (20) @(negedge clk_i);
    rd(5'h10, v); chk(v == 7, "R9 count held", v, 7);

    // R4 R5 R6: length 3, pol=1, ext enabled
    wr(5'h04, (32'd3 << 5) | 32'h8);
    wr(5'h00, 32'h2200_0007);
    wr(5'h08, 32'h1971);
    repeat (3 * DIV - 1) @(negedge clk_i);
    chk(wdt_rst_o == 1'b0, "R4 no early expiry", 32'(wdt_rst_o), 0);
    @(negedge clk_i);
    rd(5'h0C, v); chk(v == 32'h4000_0000, "R8 timeout cause", v, 32'h4000_0000);
    pulse_width(1'b1, "R6 timeout pulse high-active");
    wr(5'h00, 32'h2200_0006);
    repeat (12) @(negedge clk_i);

    // R12 restart on the expiry edge wins
    wr(5'h04, (32'd2 << 5) | 32'h8);
    wr(5'h00, 32'h2200_0007);
    wr(5'h08, 32'h1971);
    repeat (2 * DIV - 1) @(negedge clk_i);
    wr(5'h08, 32'h1971);
    chk(wdt_rst_o == 1'b0, "R12 no reset on race", 32'(wdt_rst_o), 0);
    rd(5'h10, v); chk(v == 2, "R12 count reloaded", v, 2);
    repeat (6) @(negedge clk_i);
    chk(wdt_rst_o == 1'b0, "R12 still idle", 32'(wdt_rst_o), 0);
    wr(5'h00, 32'h2200_0006);

    // R13 zero length equals one tick
    wr(5'h04, 32'h8);
    wr(5'h00, 32'h2200_0007);
    wr(5'h08, 32'h1971);
    repeat (DIV - 1) @(negedge clk_i);
    chk(wdt_rst_o == 1'b0, "R13 idle before tick", 32'(wdt_rst_o), 0);
    @(negedge clk_i);
    chk(wdt_rst_o == 1'b1, "R13 expiry after one tick", 32'(wdt_rst_o), 1);
    wr(5'h00, 32'h2200_0006);
    repeat (12) @(negedge clk_i);

    // R10 interrupt only
    wr(5'h04, (32'd1 << 5) | 32'h8);
    wr(5'h00, 32'h2200_000F);
    wr(5'h08, 32'h1971);
    repeat (DIV - 1) @(negedge clk_i);
    chk(irq_o == 1'b0, "R10 irq low before expiry", 32'(irq_o), 0);
    @(negedge clk_i);
    chk(irq_o == 1'b1 && wdt_rst_o == 1'b0, "R10 irq without reset", {irq_o, wdt_rst_o}, 2'b10);
    repeat (DIV) @(negedge clk_i);
    chk(irq_o == 1'b1 && wdt_rst_o == 1'b0, "R10 second expiry no reset", {irq_o, wdt_rst_o}, 2'b10);
    wr(5'h08, 32'h1971);
    chk(irq_o == 1'b0, "R10 restart clears irq", 32'(irq_o), 0);

    // R11 two-stage escalation
    wr(5'h00, 32'h2200_004F);
    wr(5'h08, 32'h1971);
    repeat (DIV) @(negedge clk_i);
    chk(irq_o == 1'b1 && wdt_rst_o == 1'b0, "R11 first stage irq", {irq_o, wdt_rst_o}, 2'b10);
    repeat (DIV) @(negedge clk_i);
    chk(wdt_rst_o == 1'b1, "R11 second stage reset", 32'(wdt_rst_o), 1);
    wr(5'h00, 32'h2200_0002);
    wr(5'h08, 32'h1971);
    repeat (10) @(negedge clk_i);

    // R7 software reset while disabled, pol=1
    wr(5'h14, 32'h1208);
    chk(wdt_rst_o == 1'b0, "R7 wrong swrst value ignored", 32'(wdt_rst_o), 0);
    rd(5'h0C, v); chk(v[31] == 1'b0, "R7 no sw cause yet", v, 32'h4000_0000);
    wr(5'h14, 32'h1209);
    pulse_width(1'b1, "R7 software reset pulse");
    rd(5'h0C, v); chk(v == 32'hC000_0000, "R8 both causes sticky", v, 32'hC000_0000);

    // R5 low-active idle after polarity change
    wr(5'h00, 32'h2200_0000);
    chk(wdt_rst_o == 1'b1, "R5 low-active idle high", 32'(wdt_rst_o), 1);
    wr(5'h14, 32'h1209);
    pulse_width(1'b0, "R5 low-active pulse");

    // R8 cleared by block reset
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(5'h0C, v); chk(v == 0, "R8 status cleared by reset", v, 0);

    finish_run();
  end
endmodule